// File: doc/BRIEF.md
# Four-Way Data Cache with Run-Time Write Policy

This block is a four-way set-associative data cache placed between a processor load/store port and a word-wide main-memory port. Each processor request is checked against the four tags of one set. A hit is answered from local storage. A miss chooses a victim line, writes it back if it holds modified data, and fetches the new line from memory before answering. Memory traffic uses a request/acknowledge handshake that moves one 32-bit word at a time.

Two control inputs set the policy while the cache runs. `cfg_disable` sends every access straight to memory. `cfg_wb` selects write-back when high and write-through when low. Two command pulses handle maintenance. One drops every line immediately. The other first copies every modified line back to memory and then drops every line. The default geometry is 32-bit byte addresses, 32-bit words, four-word lines and 64 sets.

Top module: `dc_cache`

## Requirements
- R1: The byte address splits into a tag (bits 31:10), a set index (bits 9:4) and a word offset (bits 3:2). The four tags of the indexed set are compared together. A read hit raises `cpu_ack` with the word on `cpu_rdata` in the cycle after the request is taken. A read hit makes no memory transfer and keeps `cpu_stall` low.
- R2: A read miss fetches the four words of the line in increasing address order, starting at the line base. It then acknowledges with the requested word.
- R3: A miss fills the lowest-numbered invalid way of the set. If all four ways are valid, it replaces the least recently used way. Recency is refreshed by every hit and every fill.
- R4: In write-back mode (`cfg_disable`=0, `cfg_wb`=1), a write hit changes only the cache and marks the line modified, with no memory traffic. A write miss fetches the line and then merges the written word into it.
- R5: A modified victim is written to memory as four words in increasing address order before the fill starts. A clean victim causes no memory writes.
- R6: In write-through mode (`cfg_disable`=0, `cfg_wb`=0), every write produces exactly one memory word write. A write hit also updates the cached word. A write miss does not allocate a line. No line is marked modified.
- R7: With `cfg_disable`=1, each request becomes one memory word transfer (a read returns the memory word). Cached contents and recency are left unchanged.
- R8: A `cmd_inval` pulse taken while idle drops every line in one cycle and writes nothing to memory. `cmd_flush` takes priority over `cmd_inval`, and `cmd_inval` takes priority over `cpu_req`.
- R9: A `cmd_flush` pulse taken while idle writes back every valid modified line, four words each, scanning sets in ascending order. It then drops every line. `cpu_stall` is high from the next cycle until the flush ends.
- R10: `cpu_stall` is high in every state other than idle, and requests are taken only while it is low. `mem_req` stays high with a stable address, direction and write data until `mem_ack`.
- R11: While reset is held, `cpu_stall`, `cpu_ack` and `mem_req` are low. Every line starts invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_disable | input | 1 | 1: every access bypasses the cache |
| cfg_wb | input | 1 | 1: write-back, 0: write-through |
| cmd_inval | input | 1 | Pulse: drop all lines without write-back |
| cmd_flush | input | 1 | Pulse: write back modified lines, then drop all lines |
| cpu_req | input | 1 | Processor request, taken when `cpu_stall` is low |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a miss, memory access or flush is in progress |
| mem_req | output | 1 | Memory word request, held until `mem_ack` |
| mem_we | output | 1 | 1: memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current word |

## Verification
Some properties are checked on every cycle. The memory request is held stable until acknowledged. The memory port is busy only while the processor is stalled. Acknowledges never come while stalled. A read hit answers one cycle later without stalling. An invalidate never starts memory traffic. A flush raises the stall at once. Other behaviour can only be shown by the bench's scenarios, because it depends on what the array held and on the data that comes back. This covers the choice of victim under LRU ordering, fill and write-back word order, whether a write-back happens at all, no-allocate on write-through misses, the stale data left in the cache by bypassed writes, and write-back versus discard across the two maintenance commands.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SINGLE,
    ST_EVICT,
    ST_FILL,
    ST_SCAN,
    ST_FWB
  } dc_state_e;
endpackage

// File: rtl/dc_lookup.sv
`timescale 1ns/1ps
// Parallel tag compare and free-way search for one set.
module dc_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22
) (
  input  logic [WAYS*TAG_W-1:0]     set_tags,
  input  logic [WAYS-1:0]           set_valid,
  input  logic [TAG_W-1:0]          req_tag,
  output logic                      hit,
  output logic [$clog2(WAYS)-1:0]   hit_way,
  output logic                      has_free,
  output logic [$clog2(WAYS)-1:0]   free_way
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] match;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = set_valid[g] && (set_tags[g*TAG_W +: TAG_W] == req_tag);
    end
  endgenerate

  always_comb begin
    hit      = |match;
    has_free = ~&set_valid;
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) free_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/dc_lru.sv
`timescale 1ns/1ps
// Per-set age ordering: age 0 is most recent, WAYS-1 is the victim.
module dc_lru #(
  parameter int SETS = 64,
  parameter int WAYS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   look_set,
  input  logic                      touch_en,
  input  logic [$clog2(SETS)-1:0]   touch_set,
  input  logic [$clog2(WAYS)-1:0]   touch_way,
  output logic [$clog2(WAYS)-1:0]   lru_way
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] ref_age;

  assign ref_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(WAYS - 1 - w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < ref_age)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[look_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/dc_cache.sv
`timescale 1ns/1ps
module dc_cache
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 64,
  parameter int WAYS       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_disable,
  input  logic              cfg_wb,
  input  logic              cmd_inval,
  input  logic              cmd_flush,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int PTR_W  = IDX_W + WAY_W;
  localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(LINE_WORDS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // storage
  logic [DATA_W-1:0] data_q  [SETS][WAYS][LINE_WORDS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];

  // control registers
  dc_state_e         state_q, state_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [WAY_W-1:0]  vic_q, vic_d;
  logic              rq_we;
  logic [ADDR_W-1:BYTE_W] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              take;

  // address fields
  logic [TAG_W-1:0] in_tag, rq_tag;
  logic [IDX_W-1:0] in_set, rq_set, ptr_set;
  logic [OFF_W-1:0] in_word, rq_word;
  logic [WAY_W-1:0] ptr_way;
  logic             unused_bytes;

  assign in_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign in_set  = cpu_addr[BYTE_W+OFF_W +: IDX_W];
  assign in_word = cpu_addr[BYTE_W +: OFF_W];
  assign rq_tag  = rq_addr[ADDR_W-1 -: TAG_W];
  assign rq_set  = rq_addr[BYTE_W+OFF_W +: IDX_W];
  assign rq_word = rq_addr[BYTE_W +: OFF_W];
  assign ptr_set = ptr_q[PTR_W-1 -: IDX_W];
  assign ptr_way = ptr_q[WAY_W-1:0];
  assign unused_bytes = ^cpu_addr[BYTE_W-1:0];

  // lookup on the incoming request
  logic [WAYS*TAG_W-1:0] set_tags;
  logic                  lk_hit, has_free;
  logic [WAY_W-1:0]      hit_way, free_way, lru_way;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_tags
      assign set_tags[g*TAG_W +: TAG_W] = tag_q[in_set][g];
    end
  endgenerate

  dc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .set_tags (set_tags),
    .set_valid(valid_q[in_set]),
    .req_tag  (in_tag),
    .hit      (lk_hit),
    .hit_way  (hit_way),
    .has_free (has_free),
    .free_way (free_way)
  );

  logic             touch_en;
  logic [IDX_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;

  dc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rst_n    (rst_ni),
    .look_set (in_set),
    .touch_en (touch_en),
    .touch_set(touch_set),
    .touch_way(touch_way),
    .lru_way  (lru_way)
  );

  // strobes into storage
  logic              dat_we, inst_en, inst_dirty, dset_en, dclr_en, inval_all;
  logic [IDX_W-1:0]  dat_set;
  logic [WAY_W-1:0]  dat_way;
  logic [OFF_W-1:0]  dat_word;
  logic [DATA_W-1:0] dat_val;

  // next-state logic
  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;  ptr_d = ptr_q;  vic_d = vic_q;
    ack_d = 1'b0;  rdata_d = rdata_q;  take = 1'b0;
    dat_we = 1'b0;  dat_set = rq_set;  dat_way = vic_q;  dat_word = cnt_q;  dat_val = mem_rdata;
    inst_en = 1'b0;  inst_dirty = 1'b0;  dset_en = 1'b0;  dclr_en = 1'b0;  inval_all = 1'b0;
    touch_en = 1'b0;  touch_set = rq_set;  touch_way = vic_q;
    mem_req = 1'b0;  mem_we = 1'b0;
    mem_addr = {rq_addr, {BYTE_W{1'b0}}};
    mem_wdata = rq_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_flush) begin
          ptr_d = '0;  state_d = ST_SCAN;
        end else if (cmd_inval) begin
          inval_all = 1'b1;
        end else if (cpu_req) begin
          take = 1'b1;
          if (cfg_disable) begin
            state_d = ST_SINGLE;
          end else if (lk_hit) begin
            touch_en = 1'b1;  touch_set = in_set;  touch_way = hit_way;
            if (!cpu_we) begin
              ack_d = 1'b1;  rdata_d = data_q[in_set][hit_way][in_word];
            end else begin
              dat_we = 1'b1;  dat_set = in_set;  dat_way = hit_way;
              dat_word = in_word;  dat_val = cpu_wdata;
              if (cfg_wb) begin dset_en = 1'b1;  ack_d = 1'b1; end
              else state_d = ST_SINGLE;
            end
          end else if (cpu_we && !cfg_wb) begin
            state_d = ST_SINGLE;
          end else begin
            cnt_d = '0;
            vic_d = has_free ? free_way : lru_way;
            state_d = (!has_free && dirty_q[in_set][lru_way]) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_SINGLE: begin
        mem_req = 1'b1;  mem_we = rq_we;
        if (mem_ack) begin ack_d = 1'b1;  rdata_d = mem_rdata;  state_d = ST_IDLE; end
      end
      ST_EVICT: begin
        mem_req = 1'b1;  mem_we = 1'b1;
        mem_addr = {tag_q[rq_set][vic_q], rq_set, cnt_q, {BYTE_W{1'b0}}};
        mem_wdata = data_q[rq_set][vic_q][cnt_q];
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req = 1'b1;
        mem_addr = {rq_tag, rq_set, cnt_q, {BYTE_W{1'b0}}};
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          dat_we = 1'b1;
          dat_val = (rq_we && cnt_q == rq_word) ? rq_wdata : mem_rdata;
          if (cnt_q == rq_word) rdata_d = dat_val;
          if (cnt_q == LAST_WORD) begin
            inst_en = 1'b1;  inst_dirty = rq_we;  touch_en = 1'b1;
            ack_d = 1'b1;  state_d = ST_IDLE;
          end
        end
      end
      ST_SCAN: begin
        if (valid_q[ptr_set][ptr_way] && dirty_q[ptr_set][ptr_way]) begin
          cnt_d = '0;  state_d = ST_FWB;
        end else if (&ptr_q) begin
          inval_all = 1'b1;  state_d = ST_IDLE;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end
      ST_FWB: begin
        mem_req = 1'b1;  mem_we = 1'b1;
        mem_addr = {tag_q[ptr_set][ptr_way], ptr_set, cnt_q, {BYTE_W{1'b0}}};
        mem_wdata = data_q[ptr_set][ptr_way][cnt_q];
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) begin
            dclr_en = 1'b1;
            if (&ptr_q) begin inval_all = 1'b1;  state_d = ST_IDLE; end
            else begin ptr_d = ptr_q + 1'b1;  state_d = ST_SCAN; end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  cnt_q <= '0;  ptr_q <= '0;  vic_q <= '0;
      ack_q <= 1'b0;  rdata_q <= '0;
      rq_we <= 1'b0;  rq_addr <= '0;  rq_wdata <= '0;
    end else begin
      state_q <= state_d;  cnt_q <= cnt_d;  ptr_q <= ptr_d;  vic_q <= vic_d;
      ack_q <= ack_d;  rdata_q <= rdata_d;
      if (take) begin
        rq_we    <= cpu_we;
        rq_addr  <= cpu_addr[ADDR_W-1:BYTE_W];
        rq_wdata <= cpu_wdata;
      end
    end
  end

  // line storage (no reset on data and tags)
  always_ff @(posedge clk) begin
    if (dat_we) data_q[dat_set][dat_way][dat_word] <= dat_val;
    if (inst_en) tag_q[rq_set][vic_q] <= rq_tag;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (inval_all) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (inst_en) begin
        valid_q[rq_set][vic_q] <= 1'b1;
        dirty_q[rq_set][vic_q] <= inst_dirty;
      end
      if (dset_en) dirty_q[dat_set][dat_way] <= 1'b1;
      if (dclr_en) dirty_q[ptr_set][ptr_way] <= 1'b0;
    end
  end

  assign cpu_stall = (state_q != ST_IDLE);
  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dc_cache_chk.sv
`timescale 1ns/1ps
module dc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_disable,
  input logic              cmd_inval,
  input logic              cmd_flush,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ack,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              lk_hit
);
  // R10: request held with stable payload until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10: memory port busy only while the processor is stalled
  p_mem_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_stall);

  // R10: completion never reported while stalled
  p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !cpu_stall);

  // R1: read hit answers next cycle without stalling
  p_hit_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_stall && !cmd_flush && !cmd_inval && !cfg_disable && lk_hit && !cpu_we
    |=> cpu_ack && !cpu_stall);

  // R8: invalidate finishes at once with no memory traffic
  p_inval_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_inval && !cmd_flush && !cpu_stall |=> !cpu_stall && !mem_req);

  // R9: flush raises stall immediately
  p_flush_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush && !cpu_stall |=> cpu_stall);
endmodule

bind dc_cache dc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_ni),
  .cfg_disable(cfg_disable),
  .cmd_inval  (cmd_inval),
  .cmd_flush  (cmd_flush),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_ack    (cpu_ack),
  .cpu_stall  (cpu_stall),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .lk_hit     (lk_hit)
);

// File: tb/dc_cache_test.sv
`timescale 1ns/1ps
module dc_cache_test;
  logic        clk, rst_n;
  logic        cfg_disable, cfg_wb, cmd_inval, cmd_flush;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_ack, cpu_stall;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int nchk, nfail;
  int rd_cnt, wr_cnt;
  logic [31:0] mem [2048];
  logic [31:0] rd_log [4];
  logic [31:0] wr_log [4];

  dc_cache uut (
    .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_wb(cfg_wb),
    .cmd_inval(cmd_inval), .cmd_flush(cmd_flush), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // memory model: acknowledges one cycle after a request, one word per two cycles
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[12:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        wr_log[0] <= wr_log[1]; wr_log[1] <= wr_log[2]; wr_log[2] <= wr_log[3]; wr_log[3] <= mem_addr;
      end else begin
        mem_rdata <= mem[mem_addr[12:2]];
        rd_cnt <= rd_cnt + 1;
        rd_log[0] <= rd_log[1]; rd_log[1] <= rd_log[2]; rd_log[2] <= rd_log[3]; rd_log[3] <= mem_addr;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  typedef struct packed {
    logic [3:0]  rid;
    logic        we;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [2:0]  nrd;
    logic [2:0]  nwr;
  } vec_t;

  // write-back mode walk through set 0; memory word i initially holds 5A000000|i
  localparam vec_t VEC [13] = '{
    '{4'd2, 1'b0, 16'h0004, 32'h0, 32'h5A000001, 3'd4, 3'd0}, // R2 cold miss -> way0
    '{4'd1, 1'b0, 16'h0008, 32'h0, 32'h5A000002, 3'd0, 3'd0}, // R1 hit
    '{4'd4, 1'b1, 16'h000C, 32'h11111111, 32'h0, 3'd0, 3'd0}, // R4 write hit, dirty
    '{4'd4, 1'b0, 16'h000C, 32'h0, 32'h11111111, 3'd0, 3'd0}, // R4 read back
    '{4'd3, 1'b0, 16'h0404, 32'h0, 32'h5A000101, 3'd4, 3'd0}, // R3 free way1
    '{4'd3, 1'b0, 16'h0808, 32'h0, 32'h5A000202, 3'd4, 3'd0}, // R3 free way2
    '{4'd3, 1'b0, 16'h0C0C, 32'h0, 32'h5A000303, 3'd4, 3'd0}, // R3 free way3
    '{4'd1, 1'b0, 16'h0000, 32'h0, 32'h5A000000, 3'd0, 3'd0}, // R1 hit refreshes way0
    '{4'd3, 1'b0, 16'h1000, 32'h0, 32'h5A000400, 3'd4, 3'd0}, // R3 evict way1 (clean)
    '{4'd3, 1'b0, 16'h0404, 32'h0, 32'h5A000101, 3'd4, 3'd0}, // R3 evict way2
    '{4'd3, 1'b0, 16'h0800, 32'h0, 32'h5A000200, 3'd4, 3'd0}, // R3 evict way3
    '{4'd5, 1'b0, 16'h0C00, 32'h0, 32'h5A000300, 3'd4, 3'd4}, // R5 dirty way0 written back
    '{4'd5, 1'b0, 16'h000C, 32'h0, 32'h11111111, 3'd4, 3'd0}  // R5 data reached memory
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_req(input string rq, input logic we, input logic [31:0] a,
                        input logic [31:0] wd, input logic [31:0] exp, input int nrd, input int nwr);
    int r0, w0, guard;
    while (cpu_stall) @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    guard = 0;
    while (!cpu_ack && guard < 400) begin @(negedge clk); guard++; end
    check({rq, " ack"}, 32'(cpu_ack), 32'd1);
    if (!we) check({rq, " rdata"}, cpu_rdata, exp);
    check({rq, " mem reads"}, 32'(rd_cnt - r0), 32'(nrd));
    check({rq, " mem writes"}, 32'(wr_cnt - w0), 32'(nwr));
  endtask

  task automatic do_cmd(input string rq, input logic flush, input int nwr);
    int w0, guard;
    while (cpu_stall) @(negedge clk);
    w0 = wr_cnt;
    cmd_flush = flush; cmd_inval = !flush;
    @(posedge clk);
    @(negedge clk);
    cmd_flush = 1'b0; cmd_inval = 1'b0;
    check({rq, " stall after command"}, 32'(cpu_stall), 32'(flush));
    guard = 0;
    while (cpu_stall && guard < 3000) begin @(negedge clk); guard++; end
    check({rq, " writes during command"}, 32'(wr_cnt - w0), 32'(nwr));
  endtask

  initial begin
    #750000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0; rd_cnt = 0; wr_cnt = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 2048; i++) mem[i] = 32'h5A000000 | 32'(i);
    for (int i = 0; i < 4; i++) begin rd_log[i] = '0; wr_log[i] = '0; end
    cfg_disable = 1'b0; cfg_wb = 1'b1; cmd_inval = 1'b0; cmd_flush = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 stall in reset", 32'(cpu_stall), 32'd0);
    check("R11 ack in reset", 32'(cpu_ack), 32'd0);
    check("R11 mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk, write-back mode
    foreach (VEC[i]) begin
      do_req($sformatf("R%0d vector %0d", VEC[i].rid, i), VEC[i].we, {16'h0, VEC[i].addr},
             VEC[i].wd, VEC[i].exp, int'(VEC[i].nrd), int'(VEC[i].nwr));
    end
    // R5 eviction order (vector 11) and R2 fill order (vector 12)
    for (int k = 0; k < 4; k++) check("R5 write-back order", wr_log[k], 32'(4 * k));
    for (int k = 0; k < 4; k++) check("R2 fill order", rd_log[k], 32'(4 * k));

    // R6 write-through
    cfg_wb = 1'b0;
    do_req("R6 wt write hit", 1'b1, 32'h000C, 32'h22222222, 32'h0, 0, 1);
    check("R6 memory updated", mem[3], 32'h22222222);
    do_req("R6 wt read back", 1'b0, 32'h000C, 32'h0, 32'h22222222, 0, 0);
    do_req("R6 wt write miss", 1'b1, 32'h2000, 32'h33333333, 32'h0, 0, 1);
    do_req("R6 no allocate", 1'b0, 32'h2000, 32'h0, 32'h33333333, 4, 0);

    // R7 bypass
    cfg_disable = 1'b1;
    do_req("R7 bypass read", 1'b0, 32'h000C, 32'h0, 32'h22222222, 1, 0);
    do_req("R7 bypass write", 1'b1, 32'h0008, 32'h44444444, 32'h0, 0, 1);
    cfg_disable = 1'b0; cfg_wb = 1'b1;
    do_req("R7 cache untouched", 1'b0, 32'h0008, 32'h0, 32'h5A000002, 0, 0);

    // R6 nothing dirty after write-through; R9 flush invalidates
    do_cmd("R6 flush of clean cache", 1'b1, 0);
    do_req("R9 refetch after flush", 1'b0, 32'h0008, 32'h0, 32'h44444444, 4, 0);

    // R8 invalidate discards modified data
    do_req("R8 wb write", 1'b1, 32'h0008, 32'h66666666, 32'h0, 0, 0);
    do_cmd("R8 invalidate", 1'b0, 0);
    do_req("R8 modified data dropped", 1'b0, 32'h0008, 32'h0, 32'h44444444, 4, 0);

    // R9 flush writes back modified lines in two sets
    do_req("R4 wb write hit", 1'b1, 32'h0004, 32'h55555555, 32'h0, 0, 0);
    do_req("R4 write miss allocates", 1'b1, 32'h0010, 32'h77777777, 32'h0, 4, 0);
    do_cmd("R9 flush", 1'b1, 8);
    for (int k = 0; k < 4; k++) check("R9 flush order set1", wr_log[k], 32'h10 + 32'(4 * k));
    do_req("R9 set0 data in memory", 1'b0, 32'h0004, 32'h0, 32'h55555555, 4, 0);
    do_req("R9 set1 data in memory", 1'b0, 32'h0010, 32'h0, 32'h77777777, 4, 0);
    for (int k = 0; k < 4; k++) check("R2 fill order set1", rd_log[k], 32'h10 + 32'(4 * k));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule